// File: doc/BRIEF.md
# Delayed Transaction Error Monitor

This block watches the delayed transactions that a bridge forwards toward its downstream bus. Each slot holds one pending request, either a read or a write. While the request waits on the far side, the slot counts the target retries it receives. Once the request has completed, the slot counts the cycles the completion waits for its originator to collect it. If a request collects 2^RETRY_W target retries, or a completion waits TIMEOUT_LIMIT cycles, the slot abandons the transaction. It signals this with a one-cycle pulse on the output that belongs to that slot.

Every abandonment latches a sticky status flag for its cause. The flags sit in one 16-bit register at byte address D0h, and software clears them by writing 1s. An abandonment also raises a one-cycle system-error pulse, but only if the global error enable is set and the disable bit for that cause is clear. The bus cycles and the queue storage are not part of this block. Their events arrive as per-slot strobes: start, retry, done and collect.

Top module: `dtem_monitor`

## Requirements
- R1: After reset the status register reads 0, and the discard pulses and the system-error pulse are all low.
- R2: A pending read slot that receives its 2^RETRY_W-th counted retry is abandoned. In the next cycle its bit of `discardReq` pulses and status bit 1 reads 1.
- R3: A pending write slot that receives its 2^RETRY_W-th counted retry is abandoned. Its bit of `discardReq` pulses and status bit 2 reads 1.
- R4: A completion that is still uncollected TIMEOUT_LIMIT cycles after `reqDone` is abandoned. Its bit of `discardCpl` pulses and status bit 0 reads 1. A `collect` in any of those cycles, the last one included, prevents the abandonment.
- R5: Retries are counted only while `retryCntEn` is 1. Retries seen while it is 0 are neither counted nor able to cause an abandonment, and the count already reached is kept.
- R6: A `reqDone` before the retry limit ends the retry count. A later request in the same slot starts again from zero retries.
- R7: Each discard pulse lasts exactly one cycle.
- R8: `serrPulse` is high for one cycle in the cycle an abandonment is flagged, only when `serrEnable` is 1 and `condDisable[k]` is 0. Here k is the status bit index of the cause: 0 timeout, 1 read, 2 write.
- R9: A write to address D0h clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R10: When a hardware set and a software clear hit the same status bit in one cycle, the bit ends up 1.
- R11: Status bits 15:3 read 0, reads from any other address return 0, and writes to any other address leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| startReq | input | NUM_SLOTS | New delayed request enters an idle slot |
| startWrite | input | NUM_SLOTS | With startReq: 1 for write, 0 for read |
| retryHit | input | NUM_SLOTS | Target retry received for the slot's request |
| reqDone | input | NUM_SLOTS | Request completed; completion now awaits collection |
| collect | input | NUM_SLOTS | Originator collected the waiting completion |
| retryCntEn | input | 1 | Enables retry counting and the retry limit |
| serrEnable | input | 1 | Global system-error enable |
| condDisable | input | 3 | Per-cause system-error disable, indexed like the status bits |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 16 | Write data (1 clears a status bit) |
| regRdData | output | 16 | Read data for regAddr |
| discardReq | output | NUM_SLOTS | One-cycle pulse: request abandoned at retry limit |
| discardCpl | output | NUM_SLOTS | One-cycle pulse: completion abandoned at timeout |
| serrPulse | output | 1 | One-cycle system-error pulse |

## Verification
A slot counter that is off by one moves the discard pulse by one cycle. The bench therefore checks the cycle just before the limit and the cycle of the limit itself. A slot stuck in the wrong state shows up the next time that slot is used: either the pulse never comes, or the wrong cause flag is latched. Faults in the status or gating logic show up one cycle after the firing event, as a wrong flag value or a wrong system-error pulse. A clear that wins over a set shows up only in the cycle where both happen together, so the bench creates that cycle on purpose.

// File: rtl/dtem_pkg.sv
package dtem_pkg;

  // Per-slot command from control to the shared counter in the datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } slotStrobe_t;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_WAIT = 2'd2
  } slotState_t;

  // Status bit positions; condDisable uses the same indices
  localparam int COND_TIMEOUT = 0;
  localparam int COND_RD      = 1;
  localparam int COND_WR      = 2;
  localparam int NUM_COND     = 3;

endpackage

// File: rtl/dtem_datapath.sv
module dtem_datapath
  import dtem_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int RETRY_W       = 24,
  parameter int TIMEOUT_LIMIT = 32768,
  parameter int ADDR_W        = 8,
  parameter int REG_W         = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  slotStrobe_t [NUM_SLOTS-1:0]   strobe,
  input  logic [NUM_COND-1:0]           statusSet,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWrData,
  output logic [NUM_SLOTS-1:0]          retryFull,
  output logic [NUM_SLOTS-1:0]          timerDone,
  output logic [REG_W-1:0]              regRdData
);

  localparam int TIMER_W = (TIMEOUT_LIMIT > 1) ? $clog2(TIMEOUT_LIMIT) : 1;
  localparam int CNT_W   = (RETRY_W > TIMER_W) ? RETRY_W : TIMER_W;
  localparam logic [CNT_W-1:0] RETRY_MAX  = CNT_W'((64'd1 << RETRY_W) - 64'd1);
  localparam logic [CNT_W-1:0] TIMER_LAST = CNT_W'(TIMEOUT_LIMIT - 1);
  localparam logic [REG_W-1:0] VALID_MASK = REG_W'((1 << NUM_COND) - 1);

  // One counter per slot, reused for retries (pending) and wait cycles (waiting)
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlotCnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobe[s].clr) begin
        cntQ <= '0;
      end else if (strobe[s].inc) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end

    assign retryFull[s] = (cntQ == RETRY_MAX);
    assign timerDone[s] = (cntQ == TIMER_LAST);
  end

  // Status register, write-one-to-clear, hardware set has priority
  logic             wrHit;
  logic [REG_W-1:0] clrMask;
  logic [REG_W-1:0] setExt;
  logic [REG_W-1:0] statusQ;

  assign wrHit   = regWrEn && (regAddr == STATUS_ADDR);
  assign clrMask = wrHit ? regWrData : '0;
  assign setExt  = REG_W'(statusSet);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= ((statusQ & ~clrMask) | setExt) & VALID_MASK;
    end
  end

  assign regRdData = (regAddr == STATUS_ADDR) ? statusQ : '0;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & $past(setExt)) == $past(setExt));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & $past(clrMask & ~setExt)) == '0);

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~VALID_MASK) == '0);

endmodule

// File: rtl/dtem_ctrl.sv
module dtem_ctrl
  import dtem_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SLOTS-1:0]          startReq,
  input  logic [NUM_SLOTS-1:0]          startWrite,
  input  logic [NUM_SLOTS-1:0]          retryHit,
  input  logic [NUM_SLOTS-1:0]          reqDone,
  input  logic [NUM_SLOTS-1:0]          collect,
  input  logic                          retryCntEn,
  input  logic                          serrEnable,
  input  logic [NUM_COND-1:0]           condDisable,
  input  logic [NUM_SLOTS-1:0]          retryFull,
  input  logic [NUM_SLOTS-1:0]          timerDone,
  output slotStrobe_t [NUM_SLOTS-1:0]   strobe,
  output logic [NUM_COND-1:0]           statusSet,
  output logic [NUM_SLOTS-1:0]          discardReq,
  output logic [NUM_SLOTS-1:0]          discardCpl,
  output logic                          serrPulse
);

  logic [NUM_SLOTS-1:0] retryFire;
  logic [NUM_SLOTS-1:0] toFire;
  logic [NUM_SLOTS-1:0] isWrite;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    slotState_t stQ;
    logic       isWrQ;
    logic       inIdle, inPend, inWait, retryCount;

    assign inIdle     = (stQ == SLOT_IDLE);
    assign inPend     = (stQ == SLOT_PEND);
    assign inWait     = (stQ == SLOT_WAIT);
    // completion takes precedence over a retry in the same cycle
    assign retryCount = inPend && !reqDone[s] && retryHit[s] && retryCntEn;
    assign retryFire[s] = retryCount && retryFull[s];
    assign toFire[s]    = inWait && !collect[s] && timerDone[s];
    assign isWrite[s]   = isWrQ;

    assign strobe[s].clr = (inIdle && startReq[s]) || (inPend && reqDone[s]);
    assign strobe[s].inc = (retryCount && !retryFull[s]) ||
                           (inWait && !collect[s] && !timerDone[s]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ   <= SLOT_IDLE;
        isWrQ <= 1'b0;
      end else begin
        unique case (stQ)
          SLOT_IDLE: if (startReq[s]) begin
            stQ   <= SLOT_PEND;
            isWrQ <= startWrite[s];
          end
          SLOT_PEND: begin
            if (reqDone[s])        stQ <= SLOT_WAIT;
            else if (retryFire[s]) stQ <= SLOT_IDLE;
          end
          SLOT_WAIT: if (collect[s] || toFire[s]) stQ <= SLOT_IDLE;
          default: stQ <= SLOT_IDLE;
        endcase
      end
    end

    // R7
    discard_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      discardReq[s] |=> !discardReq[s]);

    // R4
    cpl_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
      discardCpl[s] |-> $past(timerDone[s]) && !$past(collect[s]));
  end

  always_comb begin
    statusSet = '0;
    statusSet[COND_TIMEOUT] = |toFire;
    statusSet[COND_RD]      = |(retryFire & ~isWrite);
    statusSet[COND_WR]      = |(retryFire & isWrite);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discardReq <= '0;
      discardCpl <= '0;
      serrPulse  <= 1'b0;
    end else begin
      discardReq <= retryFire;
      discardCpl <= toFire;
      serrPulse  <= serrEnable && |(statusSet & ~condDisable);
    end
  end

  // R8
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    serrPulse |-> $past(serrEnable) && (|discardReq || |discardCpl));

  // R5
  retry_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    |discardReq |-> $past(retryCntEn));

endmodule

// File: rtl/dtem_monitor.sv
module dtem_monitor
  import dtem_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int RETRY_W       = 24,
  parameter int TIMEOUT_LIMIT = 32768,
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SLOTS-1:0]  startReq,
  input  logic [NUM_SLOTS-1:0]  startWrite,
  input  logic [NUM_SLOTS-1:0]  retryHit,
  input  logic [NUM_SLOTS-1:0]  reqDone,
  input  logic [NUM_SLOTS-1:0]  collect,
  input  logic                  retryCntEn,
  input  logic                  serrEnable,
  input  logic [2:0]            condDisable,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [15:0]           regWrData,
  output logic [15:0]           regRdData,
  output logic [NUM_SLOTS-1:0]  discardReq,
  output logic [NUM_SLOTS-1:0]  discardCpl,
  output logic                  serrPulse
);

  slotStrobe_t [NUM_SLOTS-1:0] strobe;
  logic [NUM_COND-1:0]         statusSet;
  logic [NUM_SLOTS-1:0]        retryFull;
  logic [NUM_SLOTS-1:0]        timerDone;

  dtem_ctrl #(
    .NUM_SLOTS (NUM_SLOTS)
  ) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .startWrite  (startWrite),
    .retryHit    (retryHit),
    .reqDone     (reqDone),
    .collect     (collect),
    .retryCntEn  (retryCntEn),
    .serrEnable  (serrEnable),
    .condDisable (condDisable),
    .retryFull   (retryFull),
    .timerDone   (timerDone),
    .strobe      (strobe),
    .statusSet   (statusSet),
    .discardReq  (discardReq),
    .discardCpl  (discardCpl),
    .serrPulse   (serrPulse)
  );

  dtem_datapath #(
    .NUM_SLOTS     (NUM_SLOTS),
    .RETRY_W       (RETRY_W),
    .TIMEOUT_LIMIT (TIMEOUT_LIMIT),
    .ADDR_W        (ADDR_W),
    .REG_W         (16),
    .STATUS_ADDR   (STATUS_ADDR)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .statusSet (statusSet),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .retryFull (retryFull),
    .timerDone (timerDone),
    .regRdData (regRdData)
  );

endmodule

// File: tb/dtem_monitor_test.sv
`timescale 1ns/1ps
module dtem_monitor_test;

  localparam int NS   = 2;
  localparam int RW   = 3;   // 8 retries to the limit
  localparam int TOL  = 6;   // completion wait limit
  localparam int LIM  = 1 << RW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] startReq = '0, startWrite = '0, retryHit = '0, reqDone = '0, collect = '0;
  logic          retryCntEn = 1'b1, serrEnable = 1'b1;
  logic [2:0]    condDisable = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = 8'hD0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic [NS-1:0] discardReq, discardCpl;
  logic          serrPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dtem_monitor #(.NUM_SLOTS(NS), .RETRY_W(RW), .TIMEOUT_LIMIT(TOL)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startWrite(startWrite),
    .retryHit(retryHit), .reqDone(reqDone), .collect(collect),
    .retryCntEn(retryCntEn), .serrEnable(serrEnable), .condDisable(condDisable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .discardReq(discardReq), .discardCpl(discardCpl),
    .serrPulse(serrPulse));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic readStatus(output logic [15:0] val);
    regAddr = 8'hD0;
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(logic [7:0] addr, logic [15:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    step();
    regWrEn = 1'b0; regAddr = 8'hD0; regWrData = '0;
  endtask

  task automatic startSlot(int s, bit wr);
    startReq[s] = 1'b1; startWrite[s] = wr;
    step();
    startReq = '0; startWrite = '0;
  endtask

  task automatic hits(int s, int n);
    for (int k = 0; k < n; k++) begin
      retryHit[s] = 1'b1;
      step();
      retryHit = '0;
    end
  endtask

  task automatic pulseDone(int s);
    reqDone[s] = 1'b1;
    step();
    reqDone = '0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    readStatus(v);
    check("R1 status", v, 0);
    check("R1 discardReq", discardReq, 0);
    check("R1 discardCpl", discardCpl, 0);
    check("R1 serr", serrPulse, 0);
  endtask

  task automatic testReadDiscard();
    logic [15:0] v;
    startSlot(0, 1'b0);
    hits(0, LIM - 1);
    check("R2 before limit", discardReq, 0);
    hits(0, 1);
    readStatus(v);
    check("R2 discardReq", discardReq, 2'b01);
    check("R2 status", v, 16'h0002);
    check("R8 serr fires", serrPulse, 1);
    step();
    check("R7 pulse width", discardReq, 0);
    check("R8 serr width", serrPulse, 0);
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testWriteDisabled();
    logic [15:0] v;
    condDisable = 3'b100;
    startSlot(1, 1'b1);
    hits(1, LIM);
    readStatus(v);
    check("R3 discardReq", discardReq, 2'b10);
    check("R3 status", v, 16'h0004);
    check("R8 disabled cause", serrPulse, 0);
    condDisable = 3'b000;
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testSerrOff();
    logic [15:0] v;
    serrEnable = 1'b0;
    startSlot(0, 1'b0);
    hits(0, LIM);
    readStatus(v);
    check("R8 status still latched", v, 16'h0002);
    check("R8 global enable off", serrPulse, 0);
    serrEnable = 1'b1;
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testRetryGate();
    logic [15:0] v;
    startSlot(0, 1'b0);
    hits(0, 3);
    retryCntEn = 1'b0;
    hits(0, 20);
    readStatus(v);
    check("R5 no discard while off", discardReq, 0);
    check("R5 no status while off", v, 0);
    retryCntEn = 1'b1;
    hits(0, LIM - 4);
    check("R5 count held", discardReq, 0);
    hits(0, 1);
    check("R5 discard after resume", discardReq, 2'b01);
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testCompleteBefore();
    logic [15:0] v;
    startSlot(0, 1'b0);
    hits(0, LIM - 1);
    pulseDone(0);
    collect[0] = 1'b1; step(); collect = '0;
    readStatus(v);
    check("R6 no discard on completion", discardReq | discardCpl, 0);
    check("R6 no status", v, 0);
    startSlot(0, 1'b0);
    hits(0, LIM - 1);
    check("R6 fresh count", discardReq, 0);
    hits(0, 1);
    check("R6 limit from zero", discardReq, 2'b01);
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testTimeout();
    logic [15:0] v;
    startSlot(1, 1'b1);
    pulseDone(1);
    repeat (TOL - 1) step();
    check("R4 before timeout", discardCpl, 0);
    step();
    readStatus(v);
    check("R4 discardCpl", discardCpl, 2'b10);
    check("R4 status", v, 16'h0001);
    check("R8 serr on timeout", serrPulse, 1);
    step();
    check("R7 cpl pulse width", discardCpl, 0);
    writeReg(8'hD0, 16'h0007);
  endtask

  task automatic testCollectLast();
    logic [15:0] v;
    startSlot(0, 1'b0);
    pulseDone(0);
    repeat (TOL - 1) step();
    collect[0] = 1'b1; step(); collect = '0;
    check("R4 collect on last cycle", discardCpl, 0);
    repeat (3) step();
    readStatus(v);
    check("R4 no later discard", discardCpl, 0);
    check("R4 no status", v, 0);
  endtask

  task automatic testRegisterAccess();
    logic [15:0] v;
    startSlot(0, 1'b0);
    hits(0, LIM);
    startSlot(1, 1'b1);
    pulseDone(1);
    repeat (TOL) step();
    readStatus(v);
    check("R9 two flags set", v, 16'h0003);
    writeReg(8'hD0, 16'h0000);
    readStatus(v);
    check("R9 write 0 no effect", v, 16'h0003);
    writeReg(8'hD0, 16'h0001);
    readStatus(v);
    check("R9 write 1 clears only that bit", v, 16'h0002);
    writeReg(8'hD2, 16'hFFFF);
    readStatus(v);
    check("R11 other address write ignored", v, 16'h0002);
    regAddr = 8'hD2; #1;
    check("R11 other address reads 0", regRdData, 0);
    regAddr = 8'hD0;
    // set and clear of bit 1 in the same cycle
    startSlot(0, 1'b0);
    hits(0, LIM - 1);
    retryHit[0] = 1'b1;
    writeReg(8'hD0, 16'h0002);
    retryHit = '0;
    readStatus(v);
    check("R10 set wins", v, 16'h0002);
    check("R10 discard seen", discardReq, 2'b01);
    writeReg(8'hD0, 16'hFFFF);
    readStatus(v);
    check("R9 all cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    testReset();
    testReadDiscard();
    testWriteDisabled();
    testSerrOff();
    testRetryGate();
    testCompleteBefore();
    testTimeout();
    testCollectLast();
    testRegisterAccess();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule